// File: doc/BRIEF.md
# Source/Sink Pattern Sequencer

This block plays a stored pattern onto eight timing-signal outputs and records eight live timing signals into a second memory, one entry per clock in both directions. The two memories are 8 bits wide and share an address. A host sees each address as one 16-bit word: the low byte is the playback (source) entry and the high byte is the capture (sink) entry. The host port also reaches a control register and an end-address register.

A rising edge on the source start bit plays entries 0 up to the end address. In cyclic mode the source loops back to entry 0 after the end address. A rising edge on the sink start bit starts the recorder and the player in the same cycle. If the trigger enable is set, the recorder can also start on its own when the live trigger channel rises. The recorder always stops after it writes the end address. Both counters have level-sensitive hold-in-reset bits, and both report whether they are running.

Top module: `pattern_sequencer`

## Requirements
- R1: When `host_addr[ADDR_W]` is 1, `host_addr[ADDR_W-1:0]` selects a memory word. In that word, bits 7:0 are the source entry and bits 15:8 are the sink entry. A write stores both bytes. A read returns the word on `host_rdata` after the next rising clock edge. When `host_addr[ADDR_W]` is 0, bit 0 selects the control register (0) or the end-address register (1).
- R2: Control bit 9 is the source start. When it changes from 0 to 1, `src_busy` rises one clock after the register write. In the following clocks `sig_out` presents entries 0, 1, 2, and so on. Channel order in the byte is: bit 0 trigger, bit 1 event-count reset, bit 2 bunch-count reset, bit 3 calibrate, bit 4 serial ID, bit 5 serial trigger type, bit 6 front-end reset, bit 7 spare.
- R3: With control bit 10 (cyclic) clear, the source stays busy for exactly end+1 clocks. After that, `sig_out` returns to 0.
- R4: With control bit 10 set, entry 0 follows the end-address entry, and the source stays busy.
- R5: Control bits 7:0 enable the output channels one for one. A disabled channel drives 0 on `sig_out`.
- R6: Holding the source start bit at 1, or writing it at 1 again, does not start another run. The bit must return to 0 first.
- R7: While control bit 8 is set, the source is idle and `sig_out` is 0, and a start edge is ignored.
- R8: When control bit 12 (sink start) changes from 0 to 1, both units start together. The sink writes `live_in` into sink entries 0 through end, one per clock, and then stops. It does not wrap in cyclic mode, and entry end+1 is left unchanged.
- R9: While control bit 11 is set, the sink stays idle and writes nothing.
- R10: With control bit 13 set, a rise on `live_in[0]` while the sink is idle starts only the sink. With bit 13 clear, such a rise does nothing.
- R11: While the sink is capturing, a host write keeps its source byte but discards its sink byte. Host accesses never change the length of a running capture.
- R12: After reset, both busy flags and `sig_out` are 0, and both registers read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W+1 | Top bit selects memory; lower bits are the index or register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| live_in | input | 8 | Live timing signals for capture |
| sig_out | output | 8 | Gated playback outputs |
| src_busy | output | 1 | Source is playing |
| snk_busy | output | 1 | Sink is capturing |

## Verification
The bench drives the end address from a single entry up to the full depth, and it uses the run length to catch off-by-one stops. A design that stopped one entry early or late would show a wrong busy count or a stray nonzero output. Cyclic runs are checked over two passes, so a missed wrap or an extra idle clock breaks the expected sequence. The bench also checks the entry just past the end address after a cyclic capture, which catches a recorder that wraps or overruns. Finally, it writes to the sink byte in the middle of a capture, so a port without arbitration would keep the host byte or disturb the busy length.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NCH    = 8;
  localparam int WORD_W = 16;
  localparam int CH_TRIG = 0;

  // control word fields, MSB first
  typedef struct packed {
    logic            trig_en;   // 13
    logic            snk_go;    // 12
    logic            snk_rst;   // 11
    logic            cyclic;    // 10
    logic            src_go;    // 9
    logic            src_rst;   // 8
    logic [NCH-1:0]  chan_en;   // 7:0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl,
  input  logic               wr_end,
  input  logic [WORD_W-1:0]  wdata,
  output ctl_t               ctl,
  output logic [ADDR_W-1:0]  end_addr,
  output logic               src_go_pulse,
  output logic               snk_go_pulse
);
  logic src_go_prev, snk_go_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl         <= '0;
      end_addr    <= '0;
      src_go_prev <= 1'b0;
      snk_go_prev <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= ctl_t'(wdata[CTL_W-1:0]);
      if (wr_end) end_addr <= wdata[ADDR_W-1:0];
      src_go_prev <= ctl.src_go;
      snk_go_prev <= ctl.snk_go;
    end
  end

  // start commands act on a 0->1 change of the stored bit only
  assign src_go_pulse = ctl.src_go & ~src_go_prev;
  assign snk_go_pulse = ctl.snk_go & ~snk_go_prev;
endmodule

// File: rtl/seq_mem.sv
module seq_mem
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_idx,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_word,
  input  logic [ADDR_W-1:0]  play_idx,
  output logic [NCH-1:0]     play_byte,
  input  logic               cap_we,
  input  logic [ADDR_W-1:0]  cap_idx,
  input  logic [NCH-1:0]     cap_byte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NCH-1:0] src_mem [DEPTH];
  logic [NCH-1:0] snk_mem [DEPTH];

  // no reset: contents are undefined until written
  always_ff @(posedge clk) begin
    if (host_we) src_mem[host_idx] <= host_wdata[NCH-1:0];
    if (cap_we) snk_mem[cap_idx] <= cap_byte;
    else if (host_we) snk_mem[host_idx] <= host_wdata[WORD_W-1:NCH];
  end

  assign host_word = {snk_mem[host_idx], src_mem[host_idx]};
  assign play_byte = src_mem[play_idx];
endmodule

// File: rtl/seq_player.sv
module seq_player
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               hold_rst,
  input  logic               cyclic,
  input  logic [ADDR_W-1:0]  last,
  input  logic [NCH-1:0]     chan_en,
  input  logic [NCH-1:0]     rd_byte,
  output logic [ADDR_W-1:0]  rd_idx,
  output logic               busy,
  output logic [NCH-1:0]     sig_out
);
  function automatic logic at_last(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] l);
    return a >= l;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || hold_rst) begin
      busy    <= 1'b0;
      rd_idx  <= '0;
      sig_out <= '0;
    end else begin
      sig_out <= busy ? (rd_byte & chan_en) : '0;
      if (start) begin
        busy   <= 1'b1;
        rd_idx <= '0;
      end else if (busy) begin
        if (at_last(rd_idx, last)) begin
          if (cyclic) rd_idx <= '0;
          else        busy   <= 1'b0;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_recorder.sv
module seq_recorder
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_cmd,
  input  logic               hold_rst,
  input  logic               trig_en,
  input  logic [ADDR_W-1:0]  last,
  input  logic [NCH-1:0]     live_in,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_idx,
  output logic               busy,
  output logic               trig_start
);
  logic trig_prev;
  logic start;

  function automatic logic at_last(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] l);
    return a >= l;
  endfunction

  assign trig_start = trig_en & live_in[CH_TRIG] & ~trig_prev & ~busy;
  assign start      = start_cmd | trig_start;
  assign wr_en      = busy & ~hold_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_prev <= 1'b0;
      busy      <= 1'b0;
      wr_idx    <= '0;
    end else begin
      trig_prev <= live_in[CH_TRIG];
      if (hold_rst) begin
        busy   <= 1'b0;
        wr_idx <= '0;
      end else if (start) begin
        busy   <= 1'b1;
        wr_idx <= '0;
      end else if (busy) begin
        if (at_last(wr_idx, last)) busy   <= 1'b0;
        else                       wr_idx <= wr_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_en,
  input  logic               host_we,
  input  logic [ADDR_W:0]    host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  input  logic [7:0]         live_in,
  output logic [7:0]         sig_out,
  output logic               src_busy,
  output logic               snk_busy
);
  localparam int PAD_W = WORD_W - ADDR_W;
  localparam int CPAD  = WORD_W - CTL_W;

  logic              mem_sel, wr_ctl, wr_end, mem_we;
  logic [ADDR_W-1:0] host_idx;
  ctl_t              ctl;
  logic [ADDR_W-1:0] end_addr;
  logic              src_go_pulse, snk_go_pulse;
  logic              src_start, snk_start, trig_start;
  logic [ADDR_W-1:0] play_addr, cap_addr;
  logic [NCH-1:0]    play_byte;
  logic              cap_we;
  logic [WORD_W-1:0] mem_word;

  assign mem_sel  = host_addr[ADDR_W];
  assign host_idx = host_addr[ADDR_W-1:0];
  assign wr_ctl   = host_en & host_we & ~mem_sel & ~host_addr[0];
  assign wr_end   = host_en & host_we & ~mem_sel &  host_addr[0];
  // capture owns the sink byte: the port masks host writes to it while capturing
  assign mem_we   = host_en & host_we & mem_sel;

  assign src_start = src_go_pulse | snk_go_pulse;
  assign snk_start = snk_go_pulse;

  seq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_end(wr_end), .wdata(host_wdata),
    .ctl(ctl), .end_addr(end_addr), .src_go_pulse(src_go_pulse), .snk_go_pulse(snk_go_pulse)
  );

  seq_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .host_we(mem_we), .host_idx(host_idx), .host_wdata(host_wdata),
    .host_word(mem_word), .play_idx(play_addr), .play_byte(play_byte),
    .cap_we(cap_we), .cap_idx(cap_addr), .cap_byte(live_in)
  );

  seq_player #(.ADDR_W(ADDR_W)) u_player (
    .clk(clk), .rst_n(rst_n), .start(src_start), .hold_rst(ctl.src_rst),
    .cyclic(ctl.cyclic), .last(end_addr), .chan_en(ctl.chan_en), .rd_byte(play_byte),
    .rd_idx(play_addr), .busy(src_busy), .sig_out(sig_out)
  );

  seq_recorder #(.ADDR_W(ADDR_W)) u_recorder (
    .clk(clk), .rst_n(rst_n), .start_cmd(snk_start), .hold_rst(ctl.snk_rst),
    .trig_en(ctl.trig_en), .last(end_addr), .live_in(live_in), .wr_en(cap_we),
    .wr_idx(cap_addr), .busy(snk_busy), .trig_start(trig_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_en && !host_we) begin
      if (mem_sel)           host_rdata <= mem_word;
      else if (host_addr[0]) host_rdata <= {{PAD_W{1'b0}}, end_addr};
      else                   host_rdata <= {{CPAD{1'b0}}, ctl};
    end
  end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_busy,
  input logic              snk_busy,
  input logic [7:0]        sig_out,
  input logic [7:0]        chan_en,
  input logic              cyclic,
  input logic              src_rst,
  input logic              snk_rst,
  input logic [ADDR_W-1:0] play_addr,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [ADDR_W-1:0] end_addr,
  input logic              src_start,
  input logic              snk_start
);
  // R3: one-shot source stops after the end entry
  p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_busy && !cyclic && !src_rst && !src_start && play_addr >= end_addr) |=> !src_busy);

  // R4: cyclic source returns to entry 0 and keeps running
  p_cyclic_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_busy && cyclic && !src_rst && !src_start && play_addr >= end_addr)
      |=> (src_busy && play_addr == '0));

  // R5: a disabled channel never drives a 1
  p_chan_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sig_out & ~$past(chan_en)) == 8'h00));

  // R6: the source only becomes busy from a start command
  p_start_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_busy) |-> $past(src_start));

  // R7: source reset forces idle and silent outputs
  p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    src_rst |=> (!src_busy && sig_out == 8'h00));

  // R8: sink-go starts the sink at entry 0 together with the source
  p_sink_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_start && !snk_rst && !src_rst) |=> (snk_busy && cap_addr == '0 && src_busy));

  // R8: the sink stops at the end entry and never wraps
  p_sink_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_busy && !snk_start && !snk_rst && cap_addr >= end_addr) |=> !snk_busy);

  // R9: sink reset forces idle
  p_sink_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snk_rst |=> !snk_busy);
endmodule

bind pattern_sequencer seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_busy(src_busy), .snk_busy(snk_busy),
  .sig_out(sig_out), .chan_en(ctl.chan_en), .cyclic(ctl.cyclic),
  .src_rst(ctl.src_rst), .snk_rst(ctl.snk_rst), .play_addr(play_addr),
  .cap_addr(cap_addr), .end_addr(end_addr), .src_start(src_start), .snk_start(snk_start)
);

// File: tb/tb_pattern_sequencer.sv
module tb_pattern_sequencer;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  localparam logic [15:0] B_SRC_RST = 16'h0100;
  localparam logic [15:0] B_SRC_GO  = 16'h0200;
  localparam logic [15:0] B_CYCLIC  = 16'h0400;
  localparam logic [15:0] B_SNK_RST = 16'h0800;
  localparam logic [15:0] B_SNK_GO  = 16'h1000;
  localparam logic [15:0] B_TRIG_EN = 16'h2000;
  localparam logic [AW:0] A_CTL = '0;
  localparam logic [AW:0] A_END = 1;

  logic clk = 0, rst_n = 0;
  logic host_en = 0, host_we = 0;
  logic [AW:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic [7:0] live_in = '0, sig_out;
  logic src_busy, snk_busy;

  int checks = 0, errors = 0;
  bit done = 0;
  bit cnt_on = 0;
  int busy_cnt = 0;
  logic [7:0] exp_src [DEPTH];
  logic [7:0] exp_snk [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  pattern_sequencer #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .live_in(live_in),
    .sig_out(sig_out), .src_busy(src_busy), .snk_busy(snk_busy)
  );

  always @(negedge clk) if (cnt_on && snk_busy) busy_cnt++;

  function automatic logic [AW:0] maddr(input int i);
    return {1'b1, AW'(i)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW:0] a, input logic [15:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic hread(input logic [AW:0] a, output logic [15:0] d);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_en = 0;
    d = host_rdata;
  endtask

  task automatic run_src(input int e, input logic [7:0] en, input bit cyc, input int passes);
    logic [15:0] base;
    base = {8'h00, en} | (cyc ? B_CYCLIC : 16'h0);
    hwrite(A_END, 16'(e));
    hwrite(A_CTL, base);
    hwrite(A_CTL, base | B_SRC_GO);
    @(negedge clk);
    check("R2 busy after start", 16'(src_busy), 16'h1);
    for (int j = 0; j < passes * (e + 1); j++) begin
      @(negedge clk);
      check("R2/R5 playback", 16'(sig_out), 16'(exp_src[j % (e + 1)] & en));
      if (!cyc) check("R3 busy length", 16'(src_busy), 16'(j < e));
    end
    @(negedge clk);
    if (!cyc) begin
      check("R3 silent after run", 16'(sig_out), 16'h0);
      check("R3 idle after run", 16'(src_busy), 16'h0);
    end else begin
      check("R4 wraps to entry 0", 16'(sig_out), 16'(exp_src[0] & en));
      check("R4 still busy", 16'(src_busy), 16'h1);
      hwrite(A_CTL, B_SRC_RST);
      hwrite(A_CTL, 16'h0);
    end
  endtask

  task automatic run_snk(input int e, input bit cyc, input logic [7:0] seed);
    logic [15:0] base, rd;
    base = cyc ? B_CYCLIC : 16'h0;
    hwrite(A_END, 16'(e));
    hwrite(A_CTL, base);
    hwrite(A_CTL, base | B_SNK_GO);
    @(negedge clk);
    check("R8 sink busy", 16'(snk_busy), 16'h1);
    check("R8 source started too", 16'(src_busy), 16'h1);
    live_in = seed;
    exp_snk[0] = seed;
    for (int k = 1; k <= e + 1; k++) begin
      @(negedge clk);
      check("R8 sink busy length", 16'(snk_busy), 16'(k <= e));
      live_in = seed + 8'(k * 17);
      if (k <= e) exp_snk[k] = live_in;
    end
    repeat (e + 4) @(negedge clk);
    check("R8 sink no wrap", 16'(snk_busy), 16'h0);
    hwrite(A_CTL, B_SRC_RST);
    hwrite(A_CTL, 16'h0);
    for (int k = 0; k <= e + 1; k++) begin
      hread(maddr(k), rd);
      check("R8 captured entry", rd, {exp_snk[k], exp_src[k]});
    end
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check("R12 src_busy", 16'(src_busy), 16'h0);
    check("R12 snk_busy", 16'(snk_busy), 16'h0);
    check("R12 sig_out", 16'(sig_out), 16'h0);
    hread(A_CTL, rd); check("R12 control", rd, 16'h0);
    hread(A_END, rd); check("R12 end", rd, 16'h0);

    // R1 word layout: fill and read back every word
    for (int i = 0; i < DEPTH; i++) begin
      exp_src[i] = 8'(i * 13 + 5);
      exp_snk[i] = 8'(i * 37 + 11);
      hwrite(maddr(i), {exp_snk[i], exp_src[i]});
    end
    for (int i = 0; i < DEPTH; i++) begin
      hread(maddr(i), rd);
      check("R1 readback", rd, {exp_snk[i], exp_src[i]});
    end
    hwrite(A_END, 16'h005A); hread(A_END, rd); check("R1 end reg", rd, 16'h005A);

    // R2/R3 one-shot at several lengths, R5 gating
    run_src(0, 8'hFF, 0, 1);
    run_src(1, 8'hFF, 0, 1);
    run_src(9, 8'hFF, 0, 1);
    run_src(DEPTH - 1, 8'hFF, 0, 1);
    run_src(4, 8'hA5, 0, 1);
    run_src(6, 8'h01, 0, 1);

    // R6 holding start at 1 does not restart
    hwrite(A_CTL, 16'h00FF | B_SRC_GO);
    repeat (3) @(negedge clk);
    check("R6 no restart on held bit", 16'(src_busy), 16'h0);
    check("R6 output silent", 16'(sig_out), 16'h0);

    // R4 cyclic, two passes
    run_src(5, 8'hFF, 1, 2);
    run_src(0, 8'h3C, 1, 3);

    // R7 source hold
    hwrite(A_END, 16'h5);
    hwrite(A_CTL, 16'h00FF | B_SRC_RST);
    hwrite(A_CTL, 16'h00FF | B_SRC_RST | B_SRC_GO);
    repeat (3) begin
      @(negedge clk);
      check("R7 src held idle", 16'(src_busy), 16'h0);
      check("R7 output zero", 16'(sig_out), 16'h0);
    end
    hwrite(A_CTL, 16'h0);

    // R8 capture, one-shot and cyclic
    run_snk(0, 0, 8'h4B);
    run_snk(6, 0, 8'h90);
    run_snk(6, 1, 8'h27);

    // R9 sink hold
    live_in = 8'hEE;
    hwrite(A_END, 16'h3);
    hwrite(A_CTL, B_SNK_RST);
    hwrite(A_CTL, B_SNK_RST | B_SNK_GO);
    repeat (3) begin
      @(negedge clk);
      check("R9 sink held idle", 16'(snk_busy), 16'h0);
    end
    repeat (6) @(negedge clk);
    hwrite(A_CTL, 16'h0);
    hread(maddr(0), rd);
    check("R9 no capture", rd, {exp_snk[0], exp_src[0]});

    // R10 trigger start
    live_in = 8'h00;
    hwrite(A_END, 16'h3);
    hwrite(A_CTL, B_TRIG_EN);
    repeat (2) @(negedge clk);
    live_in = 8'h01;
    @(negedge clk);
    check("R10 trigger starts sink", 16'(snk_busy), 16'h1);
    check("R10 source not started", 16'(src_busy), 16'h0);
    for (int k = 0; k < 4; k++) begin
      live_in = 8'(8'h11 + k * 16);
      exp_snk[k] = live_in;
      @(negedge clk);
    end
    check("R10 sink stops at end", 16'(snk_busy), 16'h0);
    hwrite(A_CTL, 16'h0);
    live_in = 8'h00;
    repeat (2) @(negedge clk);
    live_in = 8'h01;
    repeat (2) @(negedge clk);
    check("R10 no start when disabled", 16'(snk_busy), 16'h0);
    live_in = 8'h00;
    for (int k = 0; k < 4; k++) begin
      hread(maddr(k), rd);
      check("R10 trigger capture", rd, {exp_snk[k], exp_src[k]});
    end

    // R11 host write during capture
    live_in = 8'hC3;
    hwrite(A_END, 16'd40);
    hwrite(A_CTL, 16'h0);
    busy_cnt = 0;
    cnt_on = 1;
    hwrite(A_CTL, B_SNK_GO);
    repeat (5) @(negedge clk);
    hwrite(maddr(60), 16'hAB12);
    exp_src[60] = 8'h12;
    for (int k = 0; k <= 40; k++) exp_snk[k] = 8'hC3;
    repeat (50) @(negedge clk);
    cnt_on = 0;
    check("R11 capture length", 16'(busy_cnt), 16'd41);
    hwrite(A_CTL, 16'h0);
    hread(maddr(60), rd);
    check("R11 sink byte kept", rd, {exp_snk[60], 8'h12});

    // R1 final sweep
    for (int i = 0; i < DEPTH; i++) begin
      hread(maddr(i), rd);
      check("R1 final image", rd, {exp_snk[i], exp_src[i]});
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule